// File: doc/BRIEF.md
# SPI Serial EEPROM Slave Controller

This block is the digital control logic of a small serial EEPROM with an SPI slave port. A 2048 x 8 byte array and a small status register live in on-chip flip-flops. The block samples the chip-select, serial clock, data-in, pause and write-lock pins with the system clock. It decodes the command byte that opens each frame and carries out reads, byte and page writes, and status reads and writes. A programmable cycle counter stands in for the self-timed programming time of a real nonvolatile cell.

A host writes by first setting the write enable latch. It then sends a write command with a 16-bit address and one or more data bytes. Those bytes gather in a page buffer and are committed when chip select goes high. Three things can stop a write: a cleared latch, a busy cycle that is still running, or a block-protection setting. The pause pin lets the host stop a transfer part way through and carry on later without losing bit position.

Top module: `spi_eeprom_ctl`

## Requirements
- R1: Both SPI mode 0 (clock idles low) and mode 3 (clock idles high) work; the data-in pin is sampled on each rising clock edge, and the data-out pin changes on falling edges.
- R2: After reset the status register reads 0x00: the latch is clear, nothing is busy and no block is protected. Status layout: bit 7 lock-enable, bits 3:2 protect code, bit 1 write-enable latch, bit 0 busy, bits 6:4 zero.
- R3: Command 0x06 sets the write enable latch and command 0x04 clears it, each taking effect at chip-select rise after exactly one byte. Command 0x05 returns the status byte, repeated for as long as the clock runs.
- R4: With the latch clear, an array write (0x02) or a status write (0x01) changes nothing and starts no busy cycle.
- R5: Command 0x03 followed by a 16-bit address streams bytes from that address. Only the low 11 address bits count, and the address increments after each byte and wraps from 0x7FF to 0x000.
- R6: Write data fills a 32-byte page buffer. Bytes past the page end wrap to the page start. The page is committed only if chip select rises after a whole number of data bytes; a trailing partial byte discards the whole write.
- R7: A commit holds status bit 0 high for WRITE_CYCLES clocks and clears the latch at the end. While busy, only the status read is served; writes, reads and latch commands are ignored.
- R8: A status write changes only bits 7, 3 and 2. It is refused when bit 7 is 1 and the write-lock pin is low. An accepted status write runs a busy cycle.
- R9: Protect code 00 guards nothing, 01 guards 0x600-0x7FF, 10 guards 0x400-0x7FF and 11 guards the whole array. A write to a guarded page is discarded, starts no busy cycle and leaves the latch set.
- R10: The pause pin going low while the clock is low freezes the transfer and turns the data-out driver off. Clock edges during the pause are ignored, and the transfer resumes when the pin returns high while the clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | SPI serial clock |
| si | input | 1 | Serial data from host |
| hold_n | input | 1 | Pause request, active low |
| wp_n | input | 1 | Write-lock pin, active low |
| so | output | 1 | Serial data to host |
| so_oe | output | 1 | Output enable for so; low means high impedance |

## Verification
The bench builds the block with the default 11-bit address and 32-byte page, but sets WRITE_CYCLES to 1500. That is short enough to wait out a dozen commits, and long enough that a full status read and a second write command both fit inside one busy window, so the rules for ignoring commands while busy can be seen at the pins. With the full-size array, the bench can reach the 0x7FF-to-0x000 read wrap, the quarter and half protection boundaries, and page wrap at a real 32-byte edge.

// File: rtl/spi_eeprom_ctl.sv
module spi_eeprom_ctl #(
  parameter int ADDR_BITS    = 11,
  parameter int PAGE_BYTES   = 32,
  parameter int WRITE_CYCLES = 4000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic hold_n,
  input  logic wp_n,
  output logic so,
  output logic so_oe
);
  localparam int DEPTH = 1 << ADDR_BITS;
  localparam int PB    = $clog2(PAGE_BYTES);
  localparam int CW    = $clog2(WRITE_CYCLES + 1);
  localparam int HB    = ADDR_BITS - 8;

  localparam logic [7:0] OP_WRSR = 8'h01, OP_WRITE = 8'h02, OP_READ = 8'h03,
                         OP_WRDI = 8'h04, OP_RDSR  = 8'h05, OP_WREN = 8'h06;

  logic [1:0] cs_sy, sck_sy, si_sy, hold_sy, wp_sy;
  logic       cs_q, sck_q, held;
  logic [2:0] bcnt;
  logic [1:0] bidx;
  logic [6:0] shin;
  logic [7:0] opc, osr;
  logic [HB-1:0] ahi;
  logic [2:0] sr_in;
  logic [ADDR_BITS-1:0] addr;
  logic [ADDR_BITS-PB-1:0] page;
  logic [PB-1:0] ptr;
  logic go, wel, wpen, busy, arr_job;
  logic [1:0] bp;
  logic [CW-1:0] cyc;
  logic [7:0] pb [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pbv;
  logic [7:0] mem [DEPTH];

  wire cs_s   = cs_sy[1];
  wire sck_s  = sck_sy[1];
  wire wp_s   = wp_sy[1];
  wire cs_rise = cs_s & ~cs_q;
  wire rise   = sck_s & ~sck_q & ~cs_s & ~held;
  wire fall   = ~sck_s & sck_q & ~cs_s & ~held;
  wire [7:0] inb = {shin, si_sy[1]};
  wire [ADDR_BITS-1:0] full_addr = {ahi, inb};
  wire [7:0] status = {wpen, 3'b000, bp, wel, busy};
  wire rd_phase = (opc == OP_RDSR && bidx != 2'd0) ||
                  (opc == OP_READ && bidx == 2'd3 && go);
  wire wr_lock  = wpen & ~wp_s;

  function automatic logic guarded(input logic [1:0] code, input logic [ADDR_BITS-1:0] a);
    case (code)
      2'd0:    guarded = 1'b0;
      2'd1:    guarded = a[ADDR_BITS-1] & a[ADDR_BITS-2];
      2'd2:    guarded = a[ADDR_BITS-1];
      default: guarded = 1'b1;
    endcase
  endfunction

  assign so    = osr[7];
  assign so_oe = ~cs_s & ~held & rd_phase;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_sy <= 2'b11; sck_sy <= 2'b00; si_sy <= 2'b00; hold_sy <= 2'b11; wp_sy <= 2'b11;
      cs_q <= 1'b1; sck_q <= 1'b0;
    end else begin
      cs_sy <= {cs_sy[0], cs_n}; sck_sy <= {sck_sy[0], sck}; si_sy <= {si_sy[0], si};
      hold_sy <= {hold_sy[0], hold_n}; wp_sy <= {wp_sy[0], wp_n};
      cs_q <= cs_s; sck_q <= sck_s;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      held <= 1'b0; bcnt <= '0; bidx <= '0; shin <= '0; opc <= '0; osr <= '0;
      ahi <= '0; sr_in <= '0; addr <= '0; page <= '0; ptr <= '0; go <= 1'b0;
      wel <= 1'b0; wpen <= 1'b0; bp <= '0; busy <= 1'b0; arr_job <= 1'b0;
      cyc <= '0; pbv <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) pb[i] <= '0;
    end else begin
      if (busy) begin
        cyc <= cyc + CW'(1);
        if (cyc == CW'(WRITE_CYCLES - 1)) begin
          busy <= 1'b0;
          wel  <= 1'b0;
        end
      end
      if (cs_s) begin
        held <= 1'b0; bcnt <= '0; bidx <= '0; go <= 1'b0;
        if (cs_rise && bcnt == 3'd0 && !busy) begin
          if (opc == OP_WREN && bidx == 2'd1) wel <= 1'b1;
          if (opc == OP_WRDI && bidx == 2'd1) wel <= 1'b0;
          if (opc == OP_WRSR && bidx >= 2'd2 && wel && !wr_lock) begin
            wpen <= sr_in[2]; bp <= sr_in[1:0];
            busy <= 1'b1; arr_job <= 1'b0; cyc <= '0;
          end
          if (opc == OP_WRITE && bidx == 2'd3 && go && |pbv) begin
            busy <= 1'b1; arr_job <= 1'b1; cyc <= '0;
          end
        end
      end else begin
        if (!sck_s) held <= ~hold_sy[1];
        if (rise) begin
          shin <= inb[6:0];
          bcnt <= bcnt + 3'd1;
          if (bcnt == 3'd7) begin
            if (bidx != 2'd3) bidx <= bidx + 2'd1;
            case (bidx)
              2'd0: opc <= inb;
              2'd1: begin ahi <= inb[HB-1:0]; sr_in <= {inb[7], inb[3:2]}; end
              2'd2: begin
                addr <= full_addr;
                page <= full_addr[ADDR_BITS-1:PB];
                ptr  <= full_addr[PB-1:0];
                if (opc == OP_READ) go <= !busy;
                if (opc == OP_WRITE && !busy && wel && !guarded(bp, full_addr)) begin
                  go  <= 1'b1;
                  pbv <= '0;
                end
              end
              default:
                if (opc == OP_WRITE && go) begin
                  pb[ptr]  <= inb;
                  pbv[ptr] <= 1'b1;
                  ptr      <= ptr + PB'(1);
                end
            endcase
          end
        end
        if (fall && rd_phase) begin
          if (bcnt == 3'd0) begin
            osr <= (opc == OP_RDSR) ? status : mem[addr];
            if (opc == OP_READ) addr <= addr + ADDR_BITS'(1);
          end else begin
            osr <= {osr[6:0], 1'b0};
          end
        end
      end
    end

  always_ff @(posedge clk)
    if (busy && arr_job && cyc < CW'(PAGE_BYTES) && pbv[cyc[PB-1:0]])
      mem[{page, cyc[PB-1:0]}] <= pb[cyc[PB-1:0]];

endmodule

// File: rtl/spi_eeprom_ctl_chk.sv
module spi_eeprom_ctl_chk #(
  parameter int ADDR_BITS = 11
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 busy,
  input logic                 wel,
  input logic                 wpen,
  input logic [1:0]           bp,
  input logic                 wp_s,
  input logic                 held,
  input logic [2:0]           bcnt,
  input logic [ADDR_BITS-1:0] addr
);
  AST_BUSY_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wel)); // R4
  AST_WEL_DROPS_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel); // R7
  AST_NO_LATCH_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> !$past(busy)); // R7
  AST_STATUS_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wpen && !wp_s) |=> ($stable(bp) && wpen)); // R8
  AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    (held && $past(held)) |-> ($stable(bcnt) && $stable(addr))); // R10
endmodule

bind spi_eeprom_ctl spi_eeprom_ctl_chk #(.ADDR_BITS(ADDR_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .wel(wel), .wpen(wpen), .bp(bp),
  .wp_s(wp_s), .held(held), .bcnt(bcnt), .addr(addr)
);

// File: tb/test_spi_eeprom_ctl.sv
module test_spi_eeprom_ctl;
  localparam int HP = 6;
  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
  logic so, so_oe;
  logic mode3 = 1'b0;
  int nvec = 0, nbad = 0;

  always #2.5 clk = ~clk;

  spi_eeprom_ctl #(.ADDR_BITS(11), .PAGE_BYTES(32), .WRITE_CYCLES(1500)) i_spi_eeprom_ctl (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
    .wp_n(wp_n), .so(so), .so_oe(so_oe));

  localparam logic [23:0] VEC [0:6] = '{24'h0020_5A, 24'h07FF_C3, 24'hF805_3C,
    24'h0600_11, 24'h05FF_22, 24'h0400_33, 24'h0000_44};

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic begin_frame();
    sck = mode3; tick(HP); cs_n = 1'b0; tick(HP);
  endtask

  task automatic end_frame();
    if (!mode3) sck = 1'b0;
    tick(HP); cs_n = 1'b1; tick(2 * HP);
  endtask

  task automatic bits(input logic [7:0] tx, input int hi, input int lo, inout logic [7:0] rx);
    for (int i = hi; i >= lo; i--) begin
      sck = 1'b0; si = tx[i]; tick(HP);
      rx[i] = so_oe ? so : 1'b0;
      sck = 1'b1; tick(HP);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    logic [7:0] r = '0;
    bits(tx, 7, 0, r);
    rx = r;
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] d;
    begin_frame(); xfer(op, d); end_frame();
  endtask

  task automatic rdsr(output logic [7:0] s);
    logic [7:0] d;
    begin_frame(); xfer(8'h05, d); xfer(8'h00, s); end_frame();
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] d;
    begin_frame(); xfer(8'h01, d); xfer(v, d); end_frame();
  endtask

  task automatic write1(input logic [15:0] a, input logic [7:0] v);
    logic [7:0] d;
    begin_frame(); xfer(8'h02, d); xfer(a[15:8], d); xfer(a[7:0], d); xfer(v, d); end_frame();
  endtask

  task automatic read1(input logic [15:0] a, output logic [7:0] v);
    logic [7:0] d;
    begin_frame(); xfer(8'h03, d); xfer(a[15:8], d); xfer(a[7:0], d); xfer(8'h00, v); end_frame();
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int k = 0; k < 100; k++) begin
      rdsr(s);
      if (!s[0]) break;
    end
  endtask

  initial begin
    tick(50000 * 3);
    nbad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    logic [7:0] s, d, e;
    tick(4); rst_n = 1'b1; tick(4);
    check({7'd0, so_oe}, 8'h00, "R2 idle output off");
    rdsr(s); check(s, 8'h00, "R2 reset status");

    cmd1(8'h06); rdsr(s); check(s, 8'h02, "R3 latch set");
    cmd1(8'h04); rdsr(s); check(s, 8'h00, "R3 latch clear");

    for (int i = 0; i < 7; i++) begin
      mode3 = i[0];
      cmd1(8'h06);
      write1(VEC[i][23:8], VEC[i][7:0]);
      wait_idle();
      rdsr(s); check(s, 8'h00, "R7 latch cleared after cycle");
      read1(VEC[i][23:8] & 16'h07FF, d); check(d, VEC[i][7:0], "R1 R5 R6 byte readback");
    end
    mode3 = 1'b0;

    write1(16'h0020, 8'hEE); tick(10);
    rdsr(s); check(s, 8'h00, "R4 no busy without latch");
    read1(16'h0020, d); check(d, 8'h5A, "R4 data unchanged");

    begin_frame(); xfer(8'h03, d); xfer(8'h07, d); xfer(8'hFF, d);
    xfer(8'h00, d); check(d, 8'hC3, "R5 last address");
    xfer(8'h00, d); check(d, 8'h44, "R5 wrap to zero");
    end_frame();

    cmd1(8'h06);
    begin_frame(); xfer(8'h02, d); xfer(8'h00, d); xfer(8'h1E, d);
    xfer(8'hA0, d); xfer(8'hA1, d); xfer(8'hA2, d); xfer(8'hA3, d); end_frame();
    wait_idle();
    begin_frame(); xfer(8'h03, d); xfer(8'h00, d); xfer(8'h1E, d);
    xfer(8'h00, d); check(d, 8'hA0, "R6 page byte 1E");
    xfer(8'h00, d); check(d, 8'hA1, "R6 page byte 1F");
    end_frame();
    begin_frame(); xfer(8'h03, d); xfer(8'h00, d); xfer(8'h00, d);
    xfer(8'h00, d); check(d, 8'hA2, "R6 wrapped byte 00");
    xfer(8'h00, d); check(d, 8'hA3, "R6 wrapped byte 01");
    end_frame();
    read1(16'h0020, d); check(d, 8'h5A, "R6 next page untouched");

    cmd1(8'h06);
    begin_frame(); xfer(8'h02, d); xfer(8'h00, d); xfer(8'h20, d); xfer(8'h77, d);
    e = '0; bits(8'h0F, 7, 4, e); end_frame();
    rdsr(s); check(s, 8'h02, "R6 partial byte no commit");
    read1(16'h0020, d); check(d, 8'h5A, "R6 partial byte data kept");
    cmd1(8'h04);

    cmd1(8'h06);
    write1(16'h0005, 8'h99);
    rdsr(s); check(s, 8'h03, "R7 busy and latch visible");
    write1(16'h0005, 8'h55);
    wait_idle();
    rdsr(s); check(s, 8'h00, "R7 idle after cycle");
    read1(16'h0005, d); check(d, 8'h99, "R7 write during busy ignored");

    cmd1(8'h06); wrsr(8'hFF); wait_idle();
    rdsr(s); check(s, 8'h8C, "R8 only bits 7 3 2 written");

    cmd1(8'h06); wrsr(8'h04); wait_idle();
    rdsr(s); check(s, 8'h04, "R9 code 01 set");
    cmd1(8'h06); write1(16'h0600, 8'hAA); tick(10);
    rdsr(s); check(s, 8'h06, "R9 upper quarter write discarded");
    read1(16'h0600, d); check(d, 8'h11, "R9 upper quarter data kept");
    write1(16'h05FF, 8'hBB); wait_idle();
    read1(16'h05FF, d); check(d, 8'hBB, "R9 below quarter writable");

    cmd1(8'h06); wrsr(8'h08); wait_idle();
    cmd1(8'h06); write1(16'h0400, 8'hAA); tick(10);
    read1(16'h0400, d); check(d, 8'h33, "R9 upper half guarded");
    cmd1(8'h04);

    cmd1(8'h06); wrsr(8'h0C); wait_idle();
    cmd1(8'h06); write1(16'h0000, 8'hAA); tick(10);
    read1(16'h0000, d); check(d, 8'hA2, "R9 whole array guarded");

    wrsr(8'h8C); wait_idle();
    rdsr(s); check(s, 8'h8C, "R8 lock enable set");
    wp_n = 1'b0;
    cmd1(8'h06); wrsr(8'h00); tick(10);
    rdsr(s); check(s, 8'h8E, "R8 status write refused when locked");
    wp_n = 1'b1;
    wrsr(8'h00); wait_idle();
    rdsr(s); check(s, 8'h00, "R8 status write after unlock");

    for (int m = 0; m < 2; m++) begin
      mode3 = m[0];
      begin_frame(); xfer(8'h03, d); xfer(8'h05, d); xfer(8'hFF, d);
      e = '0; bits(8'h00, 7, 4, e);
      sck = 1'b0; tick(HP);
      hold_n = 1'b0; tick(HP);
      check({7'd0, so_oe}, 8'h00, "R10 output off in pause");
      sck = 1'b1; tick(HP); sck = 1'b0; tick(HP);
      sck = 1'b1; tick(HP); sck = 1'b0; tick(HP);
      check({7'd0, so_oe}, 8'h00, "R10 still off after ignored clocks");
      hold_n = 1'b1; tick(HP);
      bits(8'h00, 3, 0, e);
      check(e, 8'hBB, "R10 byte intact across pause");
      end_frame();
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule